// File: doc/BRIEF.md
# External Device Bus Controller

This block runs read and write bursts on a multiplexed address/data bus for simple parallel devices such as NOR flash or an FPGA. A host issues one request at a time through a valid/ready handshake that carries the direction, the start address, the burst length and the write data for every beat. The controller then drives chip select, an address latch strobe, output enable, write enable and three low burst-address lines. Each read beat returns on a beat-valid strobe, and a done pulse marks the end of each transaction.

Every phase length comes from a timing input that is already expressed in clock cycles. The read side has setup, first-access, next-access, hold and turnaround counts. The write side has latch-to-write, write-low and write-high counts. The timing inputs and the 8/16-bit width select are treated as static while a transaction runs. A cross-check on the read timing refuses any request whose settings are inconsistent.

Top module: `extbus_ctrl`

## Requirements
- R1: After reset, bus_cs_n, bus_oe_n and bus_we_n are 1, bus_ale and bus_ad_oe are 0, req_ready is 1, and done, err and rd_valid are 0.
- R2: The cycle after a request is accepted is the latch cycle. In it, bus_cs_n is 0, bus_ale is 1, bus_ad_oe is 1, bus_ad_out carries req_addr and bus_a_lo carries req_addr[2:0]. bus_ale is 0 in every other cycle.
- R3: The latch cycle is cycle 0. The first read sample is taken in cycle 1+cfg_acc_first. In the next cycle, rd_valid is 1 and rd_data holds the bus_ad_in value of the sample cycle.
- R4: Each further read beat is sampled cfg_acc_next cycles after the one before it. A value of 0 acts as 1.
- R5: On a read, bus_oe_n is 0 from cycle cfg_rd_setup through the last sample cycle. A setup of 0 lowers it in the latch cycle together with chip select. The setup value does not move any sample.
- R6: bus_oe_n returns to 1 in the cycle after the last read sample, whatever the hold value.
- R7: After a read, bus_cs_n returns to 1 and done pulses for one cycle, both in cycle L+1+cfg_rd_hold, where L is the last sample cycle.
- R8: After the latch cycle of a read, bus_ad_oe stays 0. req_ready is 0 until cycle L+cfg_turn_off, so the next latch cycle comes no earlier than L+1+cfg_turn_off.
- R9: On a write, bus_we_n goes low in cycle 1+cfg_ale_wr and stays low for cfg_wr_low cycles (0 acts as 1). While it is low, bus_ad_out holds the current beat's data and bus_a_lo does not change.
- R10: Between write beats, bus_we_n is high for cfg_wr_high cycles (0 acts as 1). Data and bus_a_lo move to the next beat in the last of those cycles. The last beat is followed by a further cfg_wr_high cycles with the data held. In the cycle after that, bus_cs_n is 1, bus_ad_oe is 0 and done pulses.
- R11: bus_a_lo steps by one (modulo 8) for each beat of a read or write burst. A burst has req_len+1 beats, at most 8.
- R12: With cfg_wide=0, only data bits [7:0] are used. Written data drives bit 8 and above as 0, and rd_data bits [15:8] read as 0. With cfg_wide=1, all 16 bits are used. Write beat i is taken from req_wdata[16*i+15:16*i].
- R13: A request is refused if cfg_rd_setup >= cfg_acc_first or cfg_rd_hold >= cfg_turn_off. In that case err pulses in the cycle after acceptance, chip select stays 1, no done is given and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AD_W | Start address |
| req_len | input | BEAT_W | Beats minus one |
| req_wdata | input | MAX_BEATS*DATA_W | Write data, beat i in slice i |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_rd_setup | input | TW | Chip select to output enable, cycles |
| cfg_acc_first | input | TW | Latch negation to first sample, cycles |
| cfg_acc_next | input | TW | Sample to next sample, cycles |
| cfg_rd_hold | input | TW | Last sample to chip select release, cycles |
| cfg_turn_off | input | TW | Bus quiet time after a read, cycles |
| cfg_ale_wr | input | TW | Latch negation to write enable, cycles |
| cfg_wr_low | input | TW | Write enable low time, cycles |
| cfg_wr_high | input | TW | Write enable high time between beats, cycles |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ad_out | output | AD_W | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | DATA_W | Read data lines |
| bus_a_lo | output | BEAT_W | Low burst address |
| done | output | 1 | Transaction complete pulse |
| err | output | 1 | Refused request pulse |
| rd_valid | output | 1 | Read beat strobe |
| rd_data | output | DATA_W | Read beat data |

## Verification
The bench builds the controller with a 16-bit address/data bus, 16-bit data and 4-bit timing fields. This keeps every interval short enough to sweep each read and write timing value over its small range, in both width modes, with bursts that wrap the three low address lines. The bench drives read data as a function of the cycle number. Each returned beat therefore shows the cycle in which it was sampled, and a sample taken one cycle early or late shows up as wrong data as well as a wrong strobe time.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ALE,
    S_RACC,
    S_RPOST,
    S_WSET,
    S_WLOW,
    S_WHIGH
  } seq_state_t;

  localparam int NARROW_W = 8;
endpackage

// File: rtl/extbus_cfg_chk.sv
module extbus_cfg_chk #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] rd_setup,
  input  logic [TW-1:0] acc_first,
  input  logic [TW-1:0] acc_next,
  input  logic [TW-1:0] rd_hold,
  input  logic [TW-1:0] turn_off,
  input  logic [TW-1:0] wr_low,
  input  logic [TW-1:0] wr_high,
  output logic          cfg_bad,
  output logic [TW-1:0] acc_next_e,
  output logic [TW-1:0] wr_low_e,
  output logic [TW-1:0] wr_high_e
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_comb begin
    cfg_bad    = (rd_setup >= acc_first) || (rd_hold >= turn_off);
    acc_next_e = (acc_next == '0) ? ONE : acc_next;
    wr_low_e   = (wr_low == '0) ? ONE : wr_low;
    wr_high_e  = (wr_high == '0) ? ONE : wr_high;
  end
endmodule

// File: rtl/extbus_lane.sv
module extbus_lane
  import extbus_pkg::*;
#(
  parameter int AD_W      = 24,
  parameter int DATA_W    = 16,
  parameter int BEAT_W    = 3,
  parameter int MAX_BEATS = 1 << BEAT_W
) (
  input  logic                          clk,
  input  logic                          load,
  input  logic [MAX_BEATS*DATA_W-1:0]   wdata_flat,
  input  logic [BEAT_W-1:0]             sel,
  input  logic                          wide,
  input  logic [DATA_W-1:0]             ad_in,
  output logic [AD_W-1:0]               wr_word,
  output logic [DATA_W-1:0]             rd_word
);
  logic [DATA_W-1:0] wbuf [MAX_BEATS];
  logic [DATA_W-1:0] wsel;
  logic [DATA_W-1:0] wmask;

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < MAX_BEATS; i++)
        wbuf[i] <= wdata_flat[i*DATA_W +: DATA_W];
    end
  end

  assign wsel = wbuf[sel];

  generate
    if (DATA_W > NARROW_W) begin : g_mask
      assign wmask   = wide ? wsel  : {{(DATA_W-NARROW_W){1'b0}}, wsel[NARROW_W-1:0]};
      assign rd_word = wide ? ad_in : {{(DATA_W-NARROW_W){1'b0}}, ad_in[NARROW_W-1:0]};
    end else begin : g_pass
      logic unused_wide;
      assign unused_wide = wide;
      assign wmask   = wsel;
      assign rd_word = ad_in;
    end
    if (AD_W > DATA_W) begin : g_ext
      assign wr_word = {{(AD_W-DATA_W){1'b0}}, wmask};
    end else begin : g_same
      assign wr_word = wmask;
    end
  endgenerate
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int AD_W   = 24,
  parameter int DATA_W = 16,
  parameter int BEAT_W = 3,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [BEAT_W-1:0] req_len,
  input  logic [TW-1:0]     rd_setup,
  input  logic [TW-1:0]     acc_first,
  input  logic [TW-1:0]     acc_next_e,
  input  logic [TW-1:0]     rd_hold,
  input  logic [TW-1:0]     turn_off,
  input  logic [TW-1:0]     ale_wr,
  input  logic [TW-1:0]     wr_low_e,
  input  logic [TW-1:0]     wr_high_e,
  input  logic              cfg_bad,
  input  logic [AD_W-1:0]   wr_word,
  input  logic [DATA_W-1:0] rd_word,
  output logic              req_ready,
  output logic              load,
  output logic [BEAT_W-1:0] sel,
  output logic              cs_n,
  output logic              ale,
  output logic              oe_n,
  output logic              we_n,
  output logic              ad_oe,
  output logic [AD_W-1:0]   ad_out,
  output logic [BEAT_W-1:0] a_lo,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  seq_state_t        state;
  logic [TW-1:0]     cnt;
  logic [TW-1:0]     scnt;
  logic [TW-1:0]     mcnt;
  logic [TW:0]       m_nx;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] len_r;
  logic              is_wr;
  logic              wr_fin;

  assign req_ready = (state == S_IDLE);
  assign load      = req_ready && req_valid && !cfg_bad;
  assign sel       = (state == S_ALE) ? beat : beat + 1'b1;
  assign m_nx      = {1'b0, mcnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cs_n     <= 1'b1;
      ale      <= 1'b0;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      a_lo     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cnt      <= '0;
      scnt     <= '0;
      mcnt     <= '0;
      beat     <= '0;
      len_r    <= '0;
      is_wr    <= 1'b0;
      wr_fin   <= 1'b0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;

      // read setup: output enable follows chip select by rd_setup cycles
      if ((state == S_ALE || state == S_RACC) && !is_wr && scnt != '0) begin
        scnt <= scnt - 1'b1;
        if (scnt == TW'(1)) oe_n <= 1'b0;
      end

      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (cfg_bad) begin
              err <= 1'b1;
            end else begin
              state  <= S_ALE;
              cs_n   <= 1'b0;
              ale    <= 1'b1;
              ad_oe  <= 1'b1;
              ad_out <= req_addr;
              a_lo   <= req_addr[BEAT_W-1:0];
              beat   <= '0;
              len_r  <= req_len;
              is_wr  <= req_write;
              scnt   <= rd_setup;
              oe_n   <= req_write || (rd_setup != '0);
            end
          end
        end
        S_ALE: begin
          ale <= 1'b0;
          if (is_wr) begin
            ad_out <= wr_word;
            if (ale_wr == '0) begin
              we_n  <= 1'b0;
              state <= S_WLOW;
              cnt   <= wr_low_e - 1'b1;
            end else begin
              state <= S_WSET;
              cnt   <= ale_wr - 1'b1;
            end
          end else begin
            ad_oe <= 1'b0;
            state <= S_RACC;
            cnt   <= acc_first;
          end
        end
        S_RACC: begin
          if (cnt == '0) begin
            rd_valid <= 1'b1;
            rd_data  <= rd_word;
            if (beat == len_r) begin
              oe_n <= 1'b1;
              mcnt <= '0;
              if (rd_hold == '0) begin
                cs_n <= 1'b1;
                done <= 1'b1;
              end
              state <= (turn_off == TW'(1)) ? S_IDLE : S_RPOST;
            end else begin
              beat <= beat + 1'b1;
              a_lo <= a_lo + 1'b1;
              cnt  <= acc_next_e - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RPOST: begin
          mcnt <= m_nx[TW-1:0];
          if (m_nx == {1'b0, rd_hold}) begin
            cs_n <= 1'b1;
            done <= 1'b1;
          end
          if (m_nx == {1'b0, turn_off} - 1'b1) state <= S_IDLE;
        end
        S_WSET: begin
          if (cnt == '0) begin
            we_n  <= 1'b0;
            state <= S_WLOW;
            cnt   <= wr_low_e - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WLOW: begin
          if (cnt == '0) begin
            we_n   <= 1'b1;
            state  <= S_WHIGH;
            cnt    <= wr_high_e - 1'b1;
            wr_fin <= (beat == len_r);
            if (wr_high_e == TW'(1) && beat != len_r) begin
              beat   <= beat + 1'b1;
              a_lo   <= a_lo + 1'b1;
              ad_out <= wr_word;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHIGH: begin
          if (cnt == TW'(1) && !wr_fin) begin
            beat   <= beat + 1'b1;
            a_lo   <= a_lo + 1'b1;
            ad_out <= wr_word;
          end
          if (cnt == '0) begin
            if (wr_fin) begin
              cs_n  <= 1'b1;
              ad_oe <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              we_n  <= 1'b0;
              state <= S_WLOW;
              cnt   <= wr_low_e - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl #(
  parameter int AD_W      = 24,
  parameter int DATA_W    = 16,
  parameter int BEAT_W    = 3,
  parameter int TW        = 8,
  parameter int MAX_BEATS = 1 << BEAT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [AD_W-1:0]             req_addr,
  input  logic [BEAT_W-1:0]           req_len,
  input  logic [MAX_BEATS*DATA_W-1:0] req_wdata,
  input  logic                        cfg_wide,
  input  logic [TW-1:0]               cfg_rd_setup,
  input  logic [TW-1:0]               cfg_acc_first,
  input  logic [TW-1:0]               cfg_acc_next,
  input  logic [TW-1:0]               cfg_rd_hold,
  input  logic [TW-1:0]               cfg_turn_off,
  input  logic [TW-1:0]               cfg_ale_wr,
  input  logic [TW-1:0]               cfg_wr_low,
  input  logic [TW-1:0]               cfg_wr_high,
  output logic                        bus_cs_n,
  output logic                        bus_ale,
  output logic                        bus_oe_n,
  output logic                        bus_we_n,
  output logic [AD_W-1:0]             bus_ad_out,
  output logic                        bus_ad_oe,
  input  logic [DATA_W-1:0]           bus_ad_in,
  output logic [BEAT_W-1:0]           bus_a_lo,
  output logic                        done,
  output logic                        err,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data
);
  logic              cfg_bad;
  logic [TW-1:0]     acc_next_e;
  logic [TW-1:0]     wr_low_e;
  logic [TW-1:0]     wr_high_e;
  logic              load;
  logic [BEAT_W-1:0] sel;
  logic [AD_W-1:0]   wr_word;
  logic [DATA_W-1:0] rd_word;

  extbus_cfg_chk #(.TW(TW)) u_cfg (
    .rd_setup   (cfg_rd_setup),
    .acc_first  (cfg_acc_first),
    .acc_next   (cfg_acc_next),
    .rd_hold    (cfg_rd_hold),
    .turn_off   (cfg_turn_off),
    .wr_low     (cfg_wr_low),
    .wr_high    (cfg_wr_high),
    .cfg_bad    (cfg_bad),
    .acc_next_e (acc_next_e),
    .wr_low_e   (wr_low_e),
    .wr_high_e  (wr_high_e)
  );

  extbus_lane #(
    .AD_W(AD_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W), .MAX_BEATS(MAX_BEATS)
  ) u_lane (
    .clk        (clk),
    .load       (load),
    .wdata_flat (req_wdata),
    .sel        (sel),
    .wide       (cfg_wide),
    .ad_in      (bus_ad_in),
    .wr_word    (wr_word),
    .rd_word    (rd_word)
  );

  extbus_seq #(
    .AD_W(AD_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W), .TW(TW)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .rd_setup   (cfg_rd_setup),
    .acc_first  (cfg_acc_first),
    .acc_next_e (acc_next_e),
    .rd_hold    (cfg_rd_hold),
    .turn_off   (cfg_turn_off),
    .ale_wr     (cfg_ale_wr),
    .wr_low_e   (wr_low_e),
    .wr_high_e  (wr_high_e),
    .cfg_bad    (cfg_bad),
    .wr_word    (wr_word),
    .rd_word    (rd_word),
    .req_ready  (req_ready),
    .load       (load),
    .sel        (sel),
    .cs_n       (bus_cs_n),
    .ale        (bus_ale),
    .oe_n       (bus_oe_n),
    .we_n       (bus_we_n),
    .ad_oe      (bus_ad_oe),
    .ad_out     (bus_ad_out),
    .a_lo       (bus_a_lo),
    .done       (done),
    .err        (err),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/extbus_ctrl_chk.sv
module extbus_ctrl_chk #(
  parameter int AD_W   = 24,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ale,
  input logic              oe_n,
  input logic              we_n,
  input logic              ad_oe,
  input logic [AD_W-1:0]   ad_out,
  input logic [BEAT_W-1:0] a_lo,
  input logic              req_ready,
  input logic              done,
  input logic              err
);
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  a_r5_oe_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !cs_n);

  a_r9_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cs_n && !ale));

  a_r8_bus_released: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !ale) |-> !ad_oe);

  a_r9_held_while_low: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> ($stable(a_lo) && $stable(ad_out)));

  a_r7_done_with_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n)));

  a_r8_ready_bus_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cs_n);

  a_r13_refused_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && !done));
endmodule

bind extbus_ctrl extbus_ctrl_chk #(.AD_W(AD_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (bus_cs_n),
  .ale       (bus_ale),
  .oe_n      (bus_oe_n),
  .we_n      (bus_we_n),
  .ad_oe     (bus_ad_oe),
  .ad_out    (bus_ad_out),
  .a_lo      (bus_a_lo),
  .req_ready (req_ready),
  .done      (done),
  .err       (err)
);

// File: tb/extbus_ctrl_bench.sv
module extbus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AD_W = 16;
  localparam int DATA_W = 16;
  localparam int BEAT_W = 3;
  localparam int TW = 4;
  localparam int MAXB = 1 << BEAT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AD_W-1:0] req_addr = '0;
  logic [BEAT_W-1:0] req_len = '0;
  logic [MAXB*DATA_W-1:0] req_wdata = '0;
  logic cfg_wide = 1'b1;
  logic [TW-1:0] t_setup = 0, t_first = 1, t_next = 1, t_hold = 0, t_turn = 1;
  logic [TW-1:0] t_ale = 0, t_wlow = 1, t_whigh = 1;
  logic cs_n, ale, oe_n, we_n, ad_oe, done, err, rd_valid;
  logic [AD_W-1:0] ad_out;
  logic [DATA_W-1:0] ad_in, rd_data;
  logic [BEAT_W-1:0] a_lo;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] dat(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {b ^ 8'h5A, b + 8'h31};
  endfunction

  function automatic logic [15:0] wpat(input int i, input int seed);
    return 16'hC3A0 ^ 16'(i * 16'h1111) ^ 16'(seed * 7);
  endfunction

  function automatic logic [15:0] nar(input logic [15:0] d);
    return cfg_wide ? d : {8'h00, d[7:0]};
  endfunction

  assign ad_in = dat(cyc);

  extbus_ctrl #(.AD_W(AD_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W), .TW(TW)) u_extbus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .cfg_wide(cfg_wide), .cfg_rd_setup(t_setup), .cfg_acc_first(t_first),
    .cfg_acc_next(t_next), .cfg_rd_hold(t_hold), .cfg_turn_off(t_turn),
    .cfg_ale_wr(t_ale), .cfg_wr_low(t_wlow), .cfg_wr_high(t_whigh),
    .bus_cs_n(cs_n), .bus_ale(ale), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_ad_out(ad_out), .bus_ad_oe(ad_oe), .bus_ad_in(ad_in), .bus_a_lo(a_lo),
    .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: got=%0h exp=%0h", req, cyc, got, exp);
    end
  endtask

  // entered and left at a falling edge; returns in the latch cycle
  task automatic issue(input logic wr, input logic [15:0] addr, input int len);
    while (!req_ready) @(negedge clk);
    req_write = wr;
    req_addr  = addr;
    req_len   = BEAT_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] addr, input int len);
    int f, n, s, h, t, b, l, base;
    f = t_first; n = (t_next == 0) ? 1 : t_next; s = t_setup;
    h = t_hold; t = t_turn; b = len + 1;
    l = 1 + f + (b - 1) * n;
    issue(1'b0, addr, len);
    base = cyc;
    for (int c = 0; c <= l + t; c++) begin
      int ns;
      int rv;
      int rexp;
      ns = 0; rv = 0; rexp = 0;
      for (int i = 0; i < b; i++) begin
        if (1 + f + i * n < c) ns++;
        if (1 + f + i * n + 1 == c) begin
          rv = 1;
          rexp = int'(nar(dat(base + 1 + f + i * n)));
        end
      end
      if (ns > b - 1) ns = b - 1;
      chk("R2 ale", int'(ale), (c == 0) ? 1 : 0);
      chk("R8 ad_oe", int'(ad_oe), (c == 0) ? 1 : 0);
      chk("R5/R6 oe_n", int'(oe_n), (c >= s && c <= l) ? 0 : 1);
      chk("R7 cs_n", int'(cs_n), (c < l + 1 + h) ? 0 : 1);
      chk("R7 done", int'(done), (c == l + 1 + h) ? 1 : 0);
      chk("R8 ready", int'(req_ready), (c >= l + t) ? 1 : 0);
      chk("R3/R4 rd_valid", int'(rd_valid), rv);
      if (rv == 1) chk("R3/R12 rd_data", int'(rd_data), rexp);
      chk("R11 a_lo", int'(a_lo), (int'(addr[2:0]) + ns) % 8);
      if (c == 0) chk("R2 ad_out", int'(ad_out), int'(addr));
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [15:0] addr, input int len, input int seed);
    int w, wl, wh, p, b, e;
    w = t_ale; wl = (t_wlow == 0) ? 1 : t_wlow; wh = (t_whigh == 0) ? 1 : t_whigh;
    p = wl + wh; b = len + 1;
    e = 1 + w + (b - 1) * p + p;
    for (int i = 0; i < MAXB; i++) req_wdata[i*DATA_W +: DATA_W] = wpat(i, seed);
    issue(1'b1, addr, len);
    for (int c = 0; c <= e; c++) begin
      int j;
      int low;
      j = 0; low = 0;
      for (int i = 0; i < b; i++) begin
        if (i >= 1 && c >= 1 + w + i * p - 1) j = i;
        if (c >= 1 + w + i * p && c < 1 + w + i * p + wl) low = 1;
      end
      chk("R2 ale", int'(ale), (c == 0) ? 1 : 0);
      chk("R9/R10 we_n", int'(we_n), low ? 0 : 1);
      chk("R10 cs_n", int'(cs_n), (c >= e) ? 1 : 0);
      chk("R10 ad_oe", int'(ad_oe), (c < e) ? 1 : 0);
      chk("R10 done", int'(done), (c == e) ? 1 : 0);
      chk("R10 ready", int'(req_ready), (c >= e) ? 1 : 0);
      chk("R5 oe_n idle on write", int'(oe_n), 1);
      if (c == 0) chk("R2 ad_out", int'(ad_out), int'(addr));
      else if (c < e) chk("R9/R12 ad_out", int'(ad_out), int'(nar(wpat(j, seed))));
      chk("R11 a_lo", int'(a_lo), (int'(addr[2:0]) + j) % 8);
      @(negedge clk);
    end
  endtask

  task automatic do_bad(input logic wr);
    issue(wr, 16'h0F0F, 1);
    chk("R13 err", int'(err), 1);
    chk("R13 cs_n", int'(cs_n), 1);
    chk("R13 ready", int'(req_ready), 1);
    chk("R13 ale", int'(ale), 0);
    @(negedge clk);
    chk("R13 err clears", int'(err), 0);
    chk("R13 cs_n stays", int'(cs_n), 1);
    chk("R13 no done", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 oe_n", int'(oe_n), 1);
    chk("R1 we_n", int'(we_n), 1);
    chk("R1 ale", int'(ale), 0);
    chk("R1 ad_oe", int'(ad_oe), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 pulses", int'({done, err, rd_valid}), 0);

    // read sweep: R3 R4 R5 R6 R7 R8 R11 R12
    for (int wd = 0; wd < 2; wd++)
      for (int f = 1; f <= 3; f++)
        for (int n = 0; n <= 2; n++)
          for (int s = 0; s < f; s++)
            for (int h = 0; h <= 1; h++)
              for (int tt = h + 1; tt <= h + 2; tt++) begin
                cfg_wide = wd[0];
                t_first = TW'(f); t_next = TW'(n); t_setup = TW'(s);
                t_hold = TW'(h); t_turn = TW'(tt);
                do_read(16'hA5F0 | 16'((f + n + s) % 8), (f + n + h) % 4);
              end
    t_first = 2; t_next = 1; t_setup = 1; t_hold = 2; t_turn = 3; cfg_wide = 1'b1;
    do_read(16'h1235, 7);

    // write sweep: R9 R10 R11 R12
    for (int wd = 0; wd < 2; wd++)
      for (int a = 0; a <= 2; a++)
        for (int wl = 0; wl <= 2; wl++)
          for (int wh = 0; wh <= 2; wh++)
            for (int ln = 0; ln <= 2; ln++) begin
              cfg_wide = wd[0];
              t_ale = TW'(a); t_wlow = TW'(wl); t_whigh = TW'(wh);
              t_first = 1; t_setup = 0; t_hold = 0; t_turn = 1;
              seed++;
              do_write(16'h5A06 + 16'(a + wl), ln, seed);
            end
    t_ale = 1; t_wlow = 2; t_whigh = 3; cfg_wide = 1'b1;
    do_write(16'h7777, 7, 99);

    // refused requests: R13
    t_first = 2; t_setup = 2; t_hold = 0; t_turn = 1;
    do_bad(1'b0);
    t_first = 3; t_setup = 1; t_hold = 2; t_turn = 2;
    do_bad(1'b1);
    // a valid read right after refusal still runs
    t_hold = 1; t_turn = 2;
    do_read(16'h0003, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule